// File: doc/BRIEF.md
# Serial Flash Chip-Select and Clock Sequencer

This block frames a single serial flash transfer in time. When a start request is accepted it lowers the active-low chip select, runs the serial clock for a given number of clock periods, and then releases the chip select. It does not move any data. A shifter next to it uses the one-cycle rising and falling strobes to launch and sample bits. The clock period is set by a divider input. The idle clock level is chosen by a mode input: low for mode 0, high for mode 3. A double-data-rate input changes how a mode-3 transfer closes.

Guard spacing is fixed at one full clock period at each end. The chip select falls one period before the first rising edge and rises one period after the last rising edge. In mode 3 with double data rate the transfer must finish on a falling edge. So the clock is low when the chip select rises, and the clock goes back high half a period later.

All configuration inputs are latched when start is accepted. The done pulse is raised only after the clock has returned to its idle level.

States: `ST_IDLE` (chip select high, clock tracks the mode input), `ST_LEAD` (half-periods 0 and 1 after the chip select falls), `ST_CLOCK` (half-periods 2 to 2N+1), `ST_TAIL` (the last half-period before the chip select rises) and `ST_RECOVER` (mode-3 double data rate only: the clock is held low for half a period with the chip select high). Transitions are as follows:
- accept: `ST_IDLE` to `ST_LEAD` when start is high.
- first-rise: `ST_LEAD` to `ST_CLOCK` at half-period boundary 2.
- last-edge: `ST_CLOCK` to `ST_TAIL` at boundary 2N+1.
- release: `ST_TAIL` to `ST_IDLE`, or to `ST_RECOVER` in mode-3 double data rate.
- restore: `ST_RECOVER` to `ST_IDLE`.

Top module: `sfcs_seq`

## Requirements
- R1: Out of reset and while idle, `cs_n` is 1, `rise_stb`, `fall_stb` and `done` are 0, and `sclk` equals the `idle_high` input as it was registered on the previous clock (0 for mode 0, 1 for mode 3).
- R2: One half-period of `sclk` lasts `div`+1 system clocks, so a full period lasts 2×(`div`+1). The high and low halves are equal.
- R3: `cs_n` goes to 0 on the clock edge that accepts `start`. The first rising edge of `sclk` follows exactly 2×(`div`+1) system clocks later. In mode 3, `sclk` falls (`div`+1) system clocks after `cs_n` falls.
- R4: A transfer with `cycles` = N (N ≥ 1) produces exactly N rising edges of `sclk`, one per period.
- R5: `cs_n` returns to 1 exactly 2×(`div`+1) system clocks after the last rising edge of `sclk`.
- R6: In mode 0, `sclk` falls half a period after each rising edge, including the last one. In mode 3 with single data rate, `sclk` stays high after the last rising edge.
- R7: In mode 3 with double data rate (`idle_high`=1, `ddr`=1), `sclk` falls half a period after the last rising edge and is 0 when `cs_n` rises. `sclk` then returns to 1 half a period after `cs_n` rises.
- R8: `rise_stb` and `fall_stb` are one system clock wide. They are high in the same cycle in which `sclk` has just changed to 1 or to 0 respectively, and only while `cs_n` is 0. No strobe accompanies the return of the clock to its idle level after `cs_n` has risen.
- R9: `done` is a one-cycle pulse. It is raised on the edge where `cs_n` rises, or on the edge where `sclk` is restored to 1 in the R7 case. `cs_n` is 1 and `sclk` is at its idle level while `done` is high.
- R10: `cycles`, `idle_high`, `ddr` and `div` are captured when `start` is accepted. Changing them, or holding `start` high, during a transfer does not alter that transfer.
- R11: A `start` that is high while `done` is high is accepted on the next edge, so the next transfer's `cs_n` falls one system clock after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer; accepted only when idle |
| cycles | input | CNT_W | Number of serial clock periods N (must be ≥ 1) |
| idle_high | input | 1 | Clock mode: 0 idles low (mode 0), 1 idles high (mode 3) |
| ddr | input | 1 | Double data rate select |
| div | input | DIV_W | Half-period length minus one, in system clocks |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | One-clock strobe on each rising edge of sclk |
| fall_stb | output | 1 | One-clock strobe on each falling edge of sclk |
| done | output | 1 | One-clock pulse when the transfer has fully finished |

## Verification
The properties take three things for granted:
- `cycles` is never 0 when start is accepted.
- `idle_high` stays steady during the idle cycle just before `start`.
- The strobe checks relate a strobe to the registered clock level one cycle earlier.

The stimulus keeps to these conditions by construction. It sweeps N over 1 to 4 and `div` over 0 to 3 with both clock modes and both rates. It always applies the mode at the same falling edge as `start`. It only moves the configuration inputs to other legal values while a transfer is in progress, and restores them before `done`.

// File: rtl/sfcs_pkg.sv
package sfcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLOCK,
        ST_TAIL,
        ST_RECOVER
    } sfcs_state_e;
endpackage

// File: rtl/sfcs_half_timer.sv
module sfcs_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    // Counter restarts at every half-period boundary and while stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sfcs_fsm.sv
module sfcs_fsm
    import sfcs_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    input  logic             idle_high,
    input  logic             ddr,
    input  logic [DIV_W-1:0] div,
    input  logic             tick,
    output logic             run,
    output logic [DIV_W-1:0] limit,
    output logic             cs_n,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             done
);
    localparam int HW = CNT_W + 2;

    sfcs_state_e      state_q, state_d;
    logic [HW-1:0]    half_q;
    logic [CNT_W-1:0] n_q;
    logic             m3_q, ddr_q;
    logic [DIV_W-1:0] div_q;
    logic [HW-1:0]    bnd;
    logic [HW-1:0]    last_bnd;
    logic             lvl;

    assign bnd      = half_q + 1'b1;          // index of the boundary being reached
    assign last_bnd = {1'b0, n_q, 1'b1};      // 2N+1: final edge boundary
    assign run      = (state_q != ST_IDLE);
    assign limit    = div_q;

    // Clock level after boundary bnd: even boundaries are rising edges,
    // odd ones falling, except the closing one of a mode-3 SDR transfer.
    always_comb begin
        if (!bnd[0]) begin
            lvl = 1'b1;
        end else begin
            lvl = (bnd == last_bnd) && m3_q && !ddr_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_LEAD;
            ST_LEAD:    if (tick && bnd == HW'(2)) state_d = ST_CLOCK;
            ST_CLOCK:   if (tick && bnd == last_bnd) state_d = ST_TAIL;
            ST_TAIL:    if (tick) state_d = (m3_q && ddr_q) ? ST_RECOVER : ST_IDLE;
            ST_RECOVER: if (tick) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            done     <= 1'b0;
            half_q   <= '0;
            n_q      <= '0;
            m3_q     <= 1'b0;
            ddr_q    <= 1'b0;
            div_q    <= '0;
        end else begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
            done     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sclk   <= idle_high;
                    half_q <= '0;
                    cs_n   <= 1'b1;
                    if (start) begin
                        cs_n  <= 1'b0;
                        n_q   <= cycles;
                        m3_q  <= idle_high;
                        ddr_q <= ddr;
                        div_q <= div;
                    end
                end
                ST_LEAD, ST_CLOCK: begin
                    if (tick) begin
                        half_q <= bnd;
                        if (lvl != sclk) begin
                            sclk     <= lvl;
                            rise_stb <= lvl;
                            fall_stb <= !lvl;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        half_q <= bnd;
                        cs_n   <= 1'b1;
                        done   <= !(m3_q && ddr_q);
                    end
                end
                ST_RECOVER: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        done <= 1'b1;
                    end
                end
                default: cs_n <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sfcs_seq.sv
module sfcs_seq #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    input  logic             idle_high,
    input  logic             ddr,
    input  logic [DIV_W-1:0] div,
    output logic             cs_n,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             done
);
    logic             run;
    logic             tick;
    logic [DIV_W-1:0] limit;

    sfcs_half_timer #(.DIV_W(DIV_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (limit),
        .tick  (tick)
    );

    sfcs_fsm #(.CNT_W(CNT_W), .DIV_W(DIV_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cycles    (cycles),
        .idle_high (idle_high),
        .ddr       (ddr),
        .div       (div),
        .tick      (tick),
        .run       (run),
        .limit     (limit),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .done      (done)
    );
endmodule

// File: rtl/sfcs_seq_chk.sv
module sfcs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic rise_stb,
    input logic fall_stb,
    input logic done
);
    // R8
    strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb || fall_stb) |-> !cs_n);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R8
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (sclk && !$past(sclk)));

    // R8
    fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!sclk && $past(sclk)));

    // R8
    edge_strobed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$stable(sclk)) |-> (rise_stb || fall_stb));

    // R9
    done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sfcs_seq sfcs_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .done     (done)
);

// File: tb/sfcs_seq_tb.sv
module sfcs_seq_tb_top;
    localparam int CW = 4;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] cycles = '0;
    logic          idle_high = 1'b0;
    logic          ddr = 1'b0;
    logic [DW-1:0] div = '0;
    logic          cs_n, sclk, rise_stb, fall_stb, done;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    sfcs_seq #(.CNT_W(CW), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cycles(cycles),
        .idle_high(idle_high), .ddr(ddr), .div(div),
        .cs_n(cs_n), .sclk(sclk), .rise_stb(rise_stb),
        .fall_stb(fall_stb), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected clock level after half-period boundary b.
    function automatic int lvl(int b, int m, int d, int n);
        if (b < 1) return m;
        if (b <= 2 * n) return (b % 2 == 0) ? 1 : 0;
        if (b <= 2 * n + 2) return (m == 1 && d == 0) ? 1 : 0;
        return m;
    endfunction

    task automatic idle_check(input int m, input string req);
        @(negedge clk);
        chk(req, "idle cs_n", int'(cs_n), 1);
        chk(req, "idle sclk", int'(sclk), m);
        chk(req, "idle strobes", int'(rise_stb) + int'(fall_stb) + int'(done), 0);
    endtask

    // launch=0: transfer already accepted at the previous edge.
    // hold: keep start high while busy. scr: disturb inputs while busy.
    // chain: leave start high at the end so the next transfer follows at once.
    task automatic do_op(input int m, input int d, input int dv, input int n,
                         input bit launch, input bit hold, input bit scr, input bit chain);
        int h = dv + 1;
        int m3d = (m == 1 && d == 1) ? 1 : 0;
        int csT = (2 * n + 2) * h;
        int endT = (2 * n + 2 + m3d) * h;
        int last = chain ? endT : endT + 1;
        string tag;
        if (launch) begin
            @(negedge clk);
            start = 1'b1; idle_high = m[0]; ddr = d[0];
            div = DW'(dv); cycles = CW'(n);
        end
        for (int t = 0; t <= last; t++) begin
            int b = t / h;
            int e_cs = (t < csT) ? 0 : 1;
            int e_sc = (t > endT) ? m : lvl(b, m, d, n);
            int edge_t = (t > 0 && t % h == 0 && t < csT) ? 1 : 0;
            int e_r = (edge_t == 1 && lvl(b, m, d, n) == 1 && lvl(b - 1, m, d, n) == 0) ? 1 : 0;
            int e_f = (edge_t == 1 && lvl(b, m, d, n) == 0 && lvl(b - 1, m, d, n) == 1) ? 1 : 0;
            @(negedge clk);
            if (scr || hold) tag = "R10";
            else if (m3d == 1) tag = "R7";
            else tag = "R2/R4/R6";
            chk((t < csT) ? "R3" : "R5", "cs_n", int'(cs_n), e_cs);
            chk(tag, "sclk", int'(sclk), e_sc);
            chk("R8", "rise_stb", int'(rise_stb), e_r);
            chk("R8", "fall_stb", int'(fall_stb), e_f);
            chk("R9", "done", int'(done), (t == endT) ? 1 : 0);
            if (t == 0) begin
                if (!hold && !chain) start = 1'b0;
                if (scr) begin
                    idle_high = ~m[0]; ddr = ~d[0];
                    div = ~DW'(dv); cycles = ~CW'(n);
                end
            end
            if (t == endT - 1) begin
                idle_high = m[0]; ddr = d[0]; div = DW'(dv); cycles = CW'(n);
                start = chain ? 1'b1 : 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset cs_n", int'(cs_n), 1);
        chk("R1", "reset sclk", int'(sclk), 0);
        chk("R1", "reset done", int'(done), 0);
        rst_n = 1'b1;
        idle_check(0, "R1");
        idle_high = 1'b1;
        @(negedge clk);
        idle_check(1, "R1");
        idle_high = 1'b0;
        @(negedge clk);
        idle_check(0, "R1");

        // Full sweep of the small configuration (R2..R9).
        for (int dv = 0; dv < 4; dv++)
            for (int n = 1; n <= 4; n++)
                for (int m = 0; m < 2; m++)
                    for (int d = 0; d < 2; d++) begin
                        do_op(m, d, dv, n, 1'b1, 1'b0, 1'b0, 1'b0);
                        idle_check(m, "R1");
                    end

        // R10: start held and inputs disturbed during the transfer.
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++) begin
                do_op(m, d, 1, 2, 1'b1, 1'b1, 1'b0, 1'b0);
                idle_check(m, "R10");
                do_op(m, d, 2, 3, 1'b1, 1'b0, 1'b1, 1'b0);
                idle_check(m, "R10");
            end

        // R11: back-to-back transfers with start high during done.
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++) begin
                do_op(m, d, 0, 1, 1'b1, 1'b0, 1'b0, 1'b1);
                do_op(m, d, 0, 1, 1'b0, 1'b0, 1'b0, 1'b0);
                idle_check(m, "R11");
            end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule